// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from the internal sources of a chip into a sticky status vector and drives one interrupt line toward a host processor. The host reaches that state through a small register port: a mask it can read and write whole, two write-only aliases that set or clear selected mask bits, two read views of the status (one passive, one that empties it) and a write-only acknowledge register that retires chosen status bits.

A status bit is latched whether or not it is masked. The host line rises while any latched bit has its mask bit at 0. When a clear and a fresh event meet on the same bit in one cycle, the event is kept, so no pulse is ever lost. Only the bit positions marked as implemented can ever latch. The event sources are assigned as follows: bit 0 first receive buffer, 1 transmit data, 2 transmit transfer, 3 second receive buffer, 4 receive transfer, 5 and 6 event mailbox, 7 wake, 8 and 9 debug trace, 10 command complete, 14 initialization complete.

Top module: `irq_status_hub`

## Requirements
- R1: After reset the mask reads 0x0001, both status views read 0 and `host_irq` is 0.
- R2: A write to offset 0 replaces the whole mask, and a read of offset 0 returns the mask. A mask bit at 1 blocks its status bit from the host line.
- R3: A write to offset 1 sets each mask bit written as 1 and leaves the others unchanged.
- R4: A write to offset 2 clears each mask bit written as 1 and leaves the others unchanged.
- R5: A read of offset 3 returns the status and changes nothing.
- R6: A read of offset 4 returns the status, and at that clock edge every status bit is cleared.
- R7: A write to offset 5 clears each status bit written as 1. Bits written as 0 are unchanged, and both status views show the result.
- R8: An event pulse on a bit in the same cycle as a clear of that bit (by offset 4 or offset 5) leaves the bit set.
- R9: Events latch regardless of the mask. After each clock edge, `host_irq` equals the OR of (status AND NOT mask) as it stands after that edge, so unmasking a pending bit raises the line at that edge.
- R10: Bits 11, 12, 13 and 15 are not implemented (parameter mask 0x47FF). Events on them never latch, and they read as 0 in both status views.
- R11: Reads of offsets 1, 2, 5 and of unused offsets 6 and 7 return 0. Writes to offsets 3, 4, 6 and 7 change neither the mask nor the status. When no read is requested, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Event pulses, one per status bit |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (offset 4 clears the status at the edge) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the current state |
| host_irq | output | 1 | Host interrupt line, active high, registered |

## Verification
Directed sequences first exercise masked events, which must show in the passive view while the line stays low. They then unmask a pending bit, which tells a registered-mask check apart from an edge-triggered one. A clear-on-read with a coincident event on the same bit tells event priority apart from clear priority. Events on the unimplemented positions show whether the implemented-bit filter is applied. Random traffic then mixes sparse and dense event patterns with every offset and random write data, against a bench model written bit by bit, so that set/clear aliases, acknowledges and writes to read-only offsets are told apart from whole-register writes.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int STAT_W = 16;
  localparam int ADDR_W = 3;

  typedef logic [STAT_W-1:0] stat_t;

  // Register offsets of the host port
  localparam logic [ADDR_W-1:0] OFS_MASK     = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_PEEK     = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_TAKE     = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_ACK      = 3'd5;

  // Next mask value from the three write views
  function automatic stat_t mask_update(input stat_t cur, input logic full_wr,
                                        input logic set_wr, input logic clr_wr,
                                        input stat_t wd);
    stat_t n;
    n = cur;
    if (full_wr) n = wd;
    if (set_wr)  n = n | wd;
    if (clr_wr)  n = n & ~wd;
    return n;
  endfunction

  // Next status: clear first, then new events win
  function automatic stat_t status_update(input stat_t cur, input stat_t clr,
                                          input stat_t evt, input stat_t impl);
    return (cur & ~clr) | (evt & impl);
  endfunction

  function automatic logic irq_level(input stat_t st, input stat_t msk);
    return |(st & ~msk);
  endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              mask_wr,
  output logic              set_wr,
  output logic              clr_wr,
  output logic              ack_wr,
  output logic              mask_rd,
  output logic              peek_rd,
  output logic              take_rd
);
  always_comb begin
    mask_wr = wr && (addr == OFS_MASK);
    set_wr  = wr && (addr == OFS_MASK_SET);
    clr_wr  = wr && (addr == OFS_MASK_CLR);
    ack_wr  = wr && (addr == OFS_ACK);
    mask_rd = rd && (addr == OFS_MASK);
    peek_rd = rd && (addr == OFS_PEEK);
    take_rd = rd && (addr == OFS_TAKE);
  end
endmodule

// File: rtl/irq_hub_mask.sv
module irq_hub_mask
  import irq_hub_pkg::*;
#(
  parameter stat_t RESET_MASK = 16'h0001
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  full_wr,
  input  logic  set_wr,
  input  logic  clr_wr,
  input  stat_t wdata,
  output stat_t mask_d,
  output stat_t mask_q
);
  always_comb mask_d = mask_update(mask_q, full_wr, set_wr, clr_wr, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= RESET_MASK;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_hub_status.sv
module irq_hub_status
  import irq_hub_pkg::*;
#(
  parameter stat_t IMPL_MASK = 16'h47FF
)(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t evt,
  input  logic  take_rd,
  input  logic  ack_wr,
  input  stat_t wdata,
  output stat_t status_d,
  output stat_t status_q
);
  stat_t clr_vec;

  always_comb begin
    clr_vec = '0;
    if (take_rd)     clr_vec = '1;
    else if (ack_wr) clr_vec = wdata;
    status_d = status_update(status_q, clr_vec, evt, IMPL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter stat_t IMPL_MASK  = 16'h47FF,
  parameter stat_t RESET_MASK = 16'h0001
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              host_irq
);
  logic  mask_fire, set_fire, clr_fire, ack_fire;
  logic  mask_rd_fire, peek_fire, take_fire;
  stat_t mask_d, mask_q, status_d, status_q;

  irq_hub_decode u_dec (
    .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .mask_wr(mask_fire), .set_wr(set_fire), .clr_wr(clr_fire), .ack_wr(ack_fire),
    .mask_rd(mask_rd_fire), .peek_rd(peek_fire), .take_rd(take_fire)
  );

  irq_hub_mask #(.RESET_MASK(RESET_MASK)) u_mask (
    .clk(clk), .rst_n(rst_n), .full_wr(mask_fire), .set_wr(set_fire),
    .clr_wr(clr_fire), .wdata(reg_wdata), .mask_d(mask_d), .mask_q(mask_q)
  );

  irq_hub_status #(.IMPL_MASK(IMPL_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .take_rd(take_fire),
    .ack_wr(ack_fire), .wdata(reg_wdata), .status_d(status_d), .status_q(status_q)
  );

  // Read mux: write-only and unused offsets return zero
  always_comb begin
    reg_rdata = '0;
    if (mask_rd_fire)             reg_rdata = mask_q;
    else if (peek_fire || take_fire) reg_rdata = status_q;
  end

  // Line follows the state that the edge produces
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= irq_level(status_d, mask_d);
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter stat_t IMPL_MASK  = 16'h47FF,
  parameter stat_t RESET_MASK = 16'h0001
)(
  input logic  clk,
  input logic  rst_n,
  input stat_t evt_i,
  input stat_t reg_wdata,
  input logic  host_irq,
  input stat_t status_q,
  input stat_t mask_q,
  input logic  set_fire,
  input logic  clr_fire,
  input logic  peek_fire,
  input logic  take_fire,
  input logic  ack_fire,
  input logic  mask_fire
);
  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == RESET_MASK && status_q == '0 && !host_irq));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)
                  && (mask_q & ~$past(reg_wdata)) == ($past(mask_q) & ~$past(reg_wdata))));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> ((mask_q & $past(reg_wdata)) == '0
                  && (mask_q & ~$past(reg_wdata)) == ($past(mask_q) & ~$past(reg_wdata))));

  // R5
  peek_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_fire && !ack_fire && (evt_i & IMPL_MASK) == '0) |=> $stable(status_q));

  // R6
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> (status_q == ($past(evt_i) & IMPL_MASK)));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ((status_q & $past(reg_wdata) & ~$past(evt_i)) == '0));

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & IMPL_MASK) != '0) |=> ((status_q & $past(evt_i) & IMPL_MASK) == ($past(evt_i) & IMPL_MASK)));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (|(status_q & ~mask_q)));

  // R10
  impl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~IMPL_MASK) == '0);

  // R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_fire && !set_fire && !clr_fire) |=> $stable(mask_q));
endmodule

bind irq_status_hub irq_hub_chk #(.IMPL_MASK(IMPL_MASK), .RESET_MASK(RESET_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wdata(reg_wdata), .host_irq(host_irq),
  .status_q(status_q), .mask_q(mask_q), .set_fire(set_fire), .clr_fire(clr_fire),
  .peek_fire(peek_fire), .take_fire(take_fire), .ack_fire(ack_fire), .mask_fire(mask_fire)
);

// File: tb/irq_status_hub_bench.sv
`timescale 1ns/1ps
module irq_status_hub_bench;
  localparam logic [15:0] IMPL = 16'h47FF;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] evt_i = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_irq;

  int checks = 0, errors = 0;
  logic [15:0] m_mask, m_stat;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_status_hub u_irq_status_hub (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mask;
      3'd3, 3'd4: return m_stat;
      default: return 16'h0;
    endcase
  endfunction

  // Bit-by-bit model of one clock edge
  function automatic void model_edge(input logic [15:0] ev, input bit w, input bit r,
                                     input logic [2:0] a, input logic [15:0] wd);
    logic [15:0] nm, ns;
    for (int b = 0; b < 16; b++) begin
      nm[b] = m_mask[b];
      if (w && a == 3'd0) nm[b] = wd[b];
      if (w && a == 3'd1 && wd[b]) nm[b] = 1'b1;
      if (w && a == 3'd2 && wd[b]) nm[b] = 1'b0;
      ns[b] = m_stat[b];
      if (r && a == 3'd4) ns[b] = 1'b0;
      if (w && a == 3'd5 && wd[b]) ns[b] = 1'b0;
      if (ev[b] && IMPL[b]) ns[b] = 1'b1;
    end
    m_mask = nm;
    m_stat = ns;
  endfunction

  function automatic logic model_irq();
    logic any = 0;
    for (int b = 0; b < 16; b++) if (m_stat[b] && !m_mask[b]) any = 1;
    return any;
  endfunction

  // Called just after a negedge
  task automatic step(input logic [15:0] ev, input bit w, input bit r,
                      input logic [2:0] a, input logic [15:0] wd, input string tag);
    evt_i = ev; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
    #1;
    if (r) check({tag, " read"}, reg_rdata, exp_read(a));
    else   check("R11 idle rdata", reg_rdata, 16'h0);
    @(posedge clk);
    model_edge(ev, w, r, a, wd);
    #1;
    check({tag, " R9 irq"}, {15'h0, host_irq}, {15'h0, model_irq()});
    @(negedge clk);
    evt_i = '0; reg_wr = 0; reg_rd = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_mask = 16'h0001; m_stat = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'h0, host_irq}, 16'h0);
    step('0, 0, 1, 3'd0, '0, "R1 mask");
    step('0, 0, 1, 3'd3, '0, "R1 peek");
    // R9: masked event latches, line low
    step(16'h0001, 0, 0, 3'd0, '0, "R9 masked evt");
    step('0, 0, 1, 3'd3, '0, "R5 peek pending");
    step('0, 0, 1, 3'd3, '0, "R5 peek again");
    // R4 unmask pending bit raises line
    step('0, 1, 0, 3'd2, 16'h0001, "R4 unmask");
    // R3 mask again by set alias
    step('0, 1, 0, 3'd1, 16'h0001, "R3 set");
    step('0, 1, 0, 3'd2, 16'h0001, "R4 clr");
    // R7 ack with bit 0 set, 0 in others
    step(16'h0402, 0, 0, 3'd0, '0, "R7 prep");
    step('0, 1, 0, 3'd5, 16'h0001, "R7 ack");
    step('0, 0, 1, 3'd3, '0, "R7 view");
    // R8 take with coincident event
    step(16'h0400, 0, 1, 3'd4, '0, "R8 take+evt");
    step('0, 0, 1, 3'd4, '0, "R8 kept");
    step('0, 0, 1, 3'd3, '0, "R6 empty");
    // R8 ack with coincident event
    step(16'h0004, 0, 0, 3'd0, '0, "R8 prep");
    step(16'h0004, 1, 0, 3'd5, 16'h0004, "R8 ack+evt");
    step('0, 0, 1, 3'd3, '0, "R8 ack kept");
    // R10 unimplemented positions
    step(16'hB800, 0, 0, 3'd0, '0, "R10 evt");
    step('0, 0, 1, 3'd3, '0, "R10 peek");
    // R11 ignored writes and zero reads
    step('0, 1, 0, 3'd3, 16'hFFFF, "R11 wr peek");
    step('0, 1, 0, 3'd4, 16'hFFFF, "R11 wr take");
    step('0, 1, 0, 3'd7, 16'hFFFF, "R11 wr unused");
    step('0, 0, 1, 3'd0, '0, "R11 mask kept");
    for (int a = 1; a < 8; a++)
      if (a != 3 && a != 4) step('0, 0, 1, 3'(a), '0, "R11 wo read");
    // R2 full mask write
    step('0, 1, 0, 3'd0, 16'h5A5A, "R2 write");
    step('0, 0, 1, 3'd0, '0, "R2 read");
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ev, wd;
      logic [2:0] a;
      bit w, r;
      ev = (i % 3 == 0) ? 16'($urandom) : (16'($urandom) & 16'($urandom) & 16'($urandom));
      wd = 16'($urandom);
      a  = 3'($urandom);
      w  = ($urandom % 3) == 0;
      r  = !w && ($urandom % 2);
      step(ev, w, r, a, wd, "R2-R11 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule